// File: doc/BRIEF.md
# Pipelined Leading-Run Length Encoder

This block sits behind a tapped delay line and turns each sampled thermometer-style vector into a binary run length. It receives one vector of 2^N−1 bits on every clock. For each vector it reports three things: how many leading bits, counted from the most significant end, have the value opposite to the previous vector's polarity; the polarity of the current vector; and a strobe saying that an edge was seen.

The polarity of a vector is its most significant bit. The block keeps the previous vector's polarity in a register. Because of this it looks for rising and falling transitions in turn, and it needs no mode input. Counting stops at the first bit that equals the previous polarity. Every bit below that point is ignored.

The logic is a two-stage pipeline and accepts a new vector on every cycle. Stage one registers a leading-run mask built by a log-depth suffix-AND tree. Stage two turns the boundary of that mask into a binary number through an OR tree.

Top module: `lead_run_encoder`

## Requirements
- R1: `edge_pol` equals bit 2^N−2, the most significant bit of `tap_vec`, of the vector presented exactly two clock edges earlier.
- R2: `edge_seen` is high exactly when that vector's most significant bit differs from the most significant bit of the vector presented one cycle before it. Directly after reset the previous polarity counts as 0.
- R3: `run_len` equals the number of consecutive bits of the vector that differ from the previous polarity. Counting starts at the most significant bit and stops at the first bit equal to the previous polarity.
- R4: Bits below the first bit equal to the previous polarity have no effect on `run_len`, `edge_pol` or `edge_seen`.
- R5: A vector whose bits all differ from the previous polarity gives `run_len` = 2^N−1, the full input width.
- R6: When `edge_seen` is low, `run_len` is 0.
- R7: The latency is exactly two cycles and a new vector is taken on every cycle. A stream of vectors with alternating polarity raises `edge_seen` on every cycle, and `edge_pol` toggles on every cycle.
- R8: `rst` is synchronous and active high. While it is applied, `run_len`, `edge_pol` and `edge_seen` are 0. It also clears the stored previous polarity to 0, including when it is applied in the middle of a stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tap_vec | input | 2^N−1 | Sampled delay-line vector; its most significant bit is its polarity |
| run_len | output | N | Leading-run length, two cycles after the vector |
| edge_pol | output | 1 | Polarity of the vector that produced `run_len` |
| edge_seen | output | 1 | High when that vector's polarity differs from the vector before it |

## Verification
The first stream alternates polarity and builds each vector from a leading run of every length from 1 to full width, then one opposite bit, then a random tail. This sets the length encoding and the full-width case apart from the edge strobe and the toggling polarity. The second stream fixes the run length and sweeps every possible tail. A mismatch there shows that bits after the transition leak into the result. A sweep through every possible vector value in counting order mixes repeated and changing polarities, so runs with no event (count 0) are checked against runs with an event. The last tests repeat same-polarity vectors and apply reset in the middle of a stream. They show whether the stored polarity, and not only the pipeline, is cleared.

// File: rtl/lre_pkg.sv
package lre_pkg;
  // Width of the sampled vector for a given count width.
  function automatic int vec_width(input int n);
    return (1 << n) - 1;
  endfunction
endpackage

// File: rtl/lre_polarity_track.sv
module lre_polarity_track #(
  parameter int N = 4,
  localparam int W = lre_pkg::vec_width(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] vec_i,
  output logic         prev_o,
  output logic         cur_o,
  output logic         event_o
);
  logic prev_q;

  assign cur_o   = vec_i[W-1];
  assign prev_o  = prev_q;
  assign event_o = cur_o ^ prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= cur_o;
  end
endmodule

// File: rtl/lre_mask_stage.sv
module lre_mask_stage #(
  parameter int N = 4,
  localparam int W = lre_pkg::vec_width(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] vec_i,
  input  logic         prev_i,
  input  logic         pol_i,
  input  logic         event_i,
  output logic [W-1:0] mask_o,
  output logic         pol_o,
  output logic         event_o,
  output logic         valid_o
);
  // Bit set where the sample differs from the previous polarity.
  logic [W-1:0] opp;
  assign opp = vec_i ^ {W{prev_i}};

  // Suffix-AND prefix tree: lvl[l][k] = AND of opp[k .. k+2^l-1] (clipped).
  logic [W-1:0] lvl [N+1];
  assign lvl[0] = opp;

  for (genvar l = 0; l < N; l++) begin : g_level
    for (genvar k = 0; k < W; k++) begin : g_bit
      if (k + (1 << l) < W) begin : g_pair
        assign lvl[l+1][k] = lvl[l][k] & lvl[l][k + (1 << l)];
      end else begin : g_pass
        assign lvl[l+1][k] = lvl[l][k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o  <= '0;
      pol_o   <= 1'b0;
      event_o <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      mask_o  <= lvl[N];
      pol_o   <= pol_i;
      event_o <= event_i;
      valid_o <= 1'b1;
    end
  end
endmodule

// File: rtl/lre_onehot_encode.sv
module lre_onehot_encode #(
  parameter int N = 4,
  localparam int W = lre_pkg::vec_width(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] mask_i,
  input  logic         pol_i,
  input  logic         event_i,
  input  logic         valid_i,
  output logic [N-1:0] len_o,
  output logic         pol_o,
  output logic         event_o,
  output logic         valid_o
);
  // Positions p whose run length (W - p) has bit b set.
  function automatic logic [W-1:0] sel_mask(input int b);
    logic [W-1:0] m;
    m = '0;
    for (int p = 0; p < W; p++) begin
      m[p] = (((W - p) >> b) & 1) != 0;
    end
    return m;
  endfunction

  // Lowest set bit of the thermometer mask marks the end of the run.
  logic [W-1:0] boundary;
  logic [N-1:0] len_d;
  assign boundary = mask_i & ~(mask_i << 1);

  for (genvar b = 0; b < N; b++) begin : g_enc
    localparam logic [W-1:0] SEL = sel_mask(b);
    assign len_d[b] = |(boundary & SEL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_o   <= '0;
      pol_o   <= 1'b0;
      event_o <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      len_o   <= len_d;
      pol_o   <= pol_i;
      event_o <= event_i & valid_i;
      valid_o <= valid_i;
    end
  end
endmodule

// File: rtl/lead_run_encoder.sv
module lead_run_encoder #(
  parameter int N = 4,
  localparam int W = lre_pkg::vec_width(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] tap_vec,
  output logic [N-1:0] run_len,
  output logic         edge_pol,
  output logic         edge_seen
);
  logic         prev_pol;
  logic         cur_pol;
  logic         in_event;
  logic [W-1:0] s1_mask;
  logic         s1_pol;
  logic         s1_event;
  logic         s1_valid;
  logic         s2_valid;

  lre_polarity_track #(.N(N)) u_track (
    .clk     (clk),
    .rst     (rst),
    .vec_i   (tap_vec),
    .prev_o  (prev_pol),
    .cur_o   (cur_pol),
    .event_o (in_event)
  );

  lre_mask_stage #(.N(N)) u_stage1 (
    .clk     (clk),
    .rst     (rst),
    .vec_i   (tap_vec),
    .prev_i  (prev_pol),
    .pol_i   (cur_pol),
    .event_i (in_event),
    .mask_o  (s1_mask),
    .pol_o   (s1_pol),
    .event_o (s1_event),
    .valid_o (s1_valid)
  );

  lre_onehot_encode #(.N(N)) u_stage2 (
    .clk     (clk),
    .rst     (rst),
    .mask_i  (s1_mask),
    .pol_i   (s1_pol),
    .event_i (s1_event),
    .valid_i (s1_valid),
    .len_o   (run_len),
    .pol_o   (edge_pol),
    .event_o (edge_seen),
    .valid_o (s2_valid)
  );
endmodule

// File: rtl/lead_run_encoder_chk.sv
module lead_run_encoder_chk #(
  parameter int N = 4,
  localparam int W = lre_pkg::vec_width(N)
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] tap_vec,
  input logic [N-1:0] run_len,
  input logic         edge_pol,
  input logic         edge_seen
);
  // Cycles since reset release, saturating at 3.
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  p_pol_latency_r1: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd2) |-> (edge_pol == $past(tap_vec[W-1], 2)));

  p_first_edge_r2: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2) |-> (edge_seen == edge_pol));

  p_edge_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3) |-> (edge_seen == (edge_pol != $past(edge_pol))));

  p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !edge_seen |-> (run_len == '0));

  p_event_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    edge_seen |-> (run_len != '0));

  p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (run_len == '0 && !edge_pol && !edge_seen));
endmodule

bind lead_run_encoder lead_run_encoder_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tap_vec   (tap_vec),
  .run_len   (run_len),
  .edge_pol  (edge_pol),
  .edge_seen (edge_seen)
);

// File: tb/lead_run_encoder_bench.sv
module lead_run_encoder_bench;
  localparam int N = 4;
  localparam int W = (1 << N) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] tap_vec = '0;
  logic [N-1:0] run_len;
  logic         edge_pol;
  logic         edge_seen;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lead_run_encoder #(.N(N)) u_lead_run_encoder (
    .clk(clk), .rst(rst), .tap_vec(tap_vec),
    .run_len(run_len), .edge_pol(edge_pol), .edge_seen(edge_seen)
  );

  // Reference model state
  logic  m_prev;
  bit    e_ok  [2];
  int    e_len [2];
  bit    e_pol [2];
  bit    e_det [2];
  string e_tag [2];

  function automatic int model_len(input logic [W-1:0] v, input logic p);
    int c = 0;
    bit stop = 0;
    for (int k = W - 1; k >= 0; k--) begin
      if (!stop && v[k] != p) c++;
      else stop = 1;
    end
    return c;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // One cycle: check the entry driven two cycles ago, then drive a new vector.
  task automatic step(input logic [W-1:0] v, input string tag);
    @(negedge clk);
    if (e_ok[1]) begin
      chk(e_tag[1], "run_len", int'(run_len), e_len[1]);
      chk("R1", "edge_pol", int'(edge_pol), int'(e_pol[1]));
      chk("R2", "edge_seen", int'(edge_seen), int'(e_det[1]));
    end
    e_ok[1] = e_ok[0]; e_len[1] = e_len[0]; e_pol[1] = e_pol[0];
    e_det[1] = e_det[0]; e_tag[1] = e_tag[0];
    e_ok[0]  = 1;
    e_len[0] = model_len(v, m_prev);
    e_pol[0] = v[W-1];
    e_det[0] = (v[W-1] != m_prev);
    e_tag[0] = (tag == "") ? (e_det[0] ? "R3" : "R6") : tag;
    m_prev   = v[W-1];
    tap_vec  = v;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    tap_vec = '0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8", "run_len in reset", int'(run_len), 0);
      chk("R8", "edge_pol in reset", int'(edge_pol), 0);
      chk("R8", "edge_seen in reset", int'(edge_seen), 0);
    end
    e_ok[0] = 0; e_ok[1] = 0;
    m_prev = 1'b0;
    rst = 1'b0;
  endtask

  // Vector: i leading bits of polarity p, one opposite bit, random tail.
  function automatic logic [W-1:0] build(input int i, input logic p, input logic [W-1:0] tail);
    logic [W-1:0] v = tail;
    for (int k = 0; k < W; k++) begin
      if (k < i) v[W-1-k] = p;
      else if (k == i) v[W-1-k] = ~p;
    end
    return v;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic p;
    e_ok[0] = 0; e_ok[1] = 0;
    m_prev = 0;
    do_reset();

    // R7 / R3 / R5: alternating polarity, every run length, random tails
    p = 1'b1;
    for (int pass = 0; pass < 3; pass++) begin
      for (int i = 1; i <= W; i++) begin
        step(build(i, p, W'($urandom)), (i == W) ? "R5" : "R7");
        p = ~p;
      end
    end

    // R4: fixed run length, every tail value
    for (int t = 0; t < (1 << (W - 4)); t++) begin
      step(build(3, p, W'(t)), "R4");
      p = ~p;
    end

    // R3 / R6: every vector value in counting order
    for (int v = 0; v < (1 << W); v++) begin
      step(W'(v), "");
    end

    // R6: repeated same polarity gives no event
    for (int r = 0; r < 8; r++) step(build(r, 1'b1, W'($urandom)) | {1'b1, {(W-1){1'b0}}}, "R6");
    for (int r = 0; r < 8; r++) step(build(r, 1'b0, W'($urandom)) & {1'b0, {(W-1){1'b1}}}, "R6");

    // R8: reset mid-stream clears stored polarity; first high vector is an event
    step({W{1'b1}}, "R5");
    step({W{1'b1}}, "R6");
    step('0, "");
    step('0, "");
    do_reset();
    step({W{1'b1}}, "R8");
    step(build(5, 1'b0, W'($urandom)), "R8");
    for (int d = 0; d < 3; d++) step('0, "");

    finish_run();
  end
endmodule